// File: doc/BRIEF.md
# Four-Lane Byte/Word Data Buffer

This block holds data between a 32-bit register port and a serial engine, in both directions. Each direction has its own buffer made of four byte-wide FIFO lanes, each sixteen entries deep. A word access moves one byte through every lane at once, so the buffer holds 64 bytes when it is used word-wise. A byte access moves data through lane 0 only, so it holds 16 bytes when it is used byte-wise. The host pushes words or bytes into the transmit buffer, and the engine pops them. The engine pushes into the receive buffer, and the host pops from it. Read data on both pop sides is the current head of each lane, shown without a clock of delay, so a reader samples it before it pops.

Occupancy conditions, dropped accesses and an engine completion pulse feed a 13-bit status register. Its bits are sticky: each one stays set until a write-one-to-clear access removes it. If the condition behind a bit still holds when it is cleared, the bit comes back at once. An enable mask selects which status bits drive a single level interrupt.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word push stores bits [8k+7:8k] in lane k, for k from 0 to 3. A word pop returns the four lane heads in the same positions. Words leave in the order they were pushed.
- R2: A byte push stores bits [7:0] in lane 0 only, and a byte pop removes only the lane 0 head, which is returned on bits [7:0]. Bytes leave in the order they were pushed, and lanes 1 to 3 are left unchanged.
- R3: The transmit buffer accepts 16 word pushes (64 bytes) or 16 byte pushes. A push whose target lane is full (any lane for a word, lane 0 for a byte) is dropped, leaves the stored data unchanged and sets status bit 12.
- R4: A pop whose target lane is empty (any lane for a word, lane 0 for a byte) is dropped, leaves the stored data unchanged and sets status bit 12.
- R5: The condition bits are as follows. Bit 3 is set while any transmit lane is full. Bit 2 is set while transmit lane 0 holds at least DEPTH/2 entries. Bit 1 is set while all transmit lanes are empty. Bit 8 is set while any receive lane is full. Bit 7 is set while receive lane 0 holds at least DEPTH/2 entries. Bit 6 is set while every receive lane holds data. Bit 11 is set while receive lane 0 holds data. Bits 4 and 10 always read 0. A condition bit is set one clock after the occupancy change that causes it.
- R6: A status bit stays set after its condition goes away, until it is cleared.
- R7: Clearing a bit whose condition still holds leaves it reading 1.
- R8: A clear write affects only the bits written as 1. Every other set bit is kept.
- R9: `irq` is high exactly while some status bit is set and its enable bit is set. It stays high until the status bit is cleared or its enable bit is removed.
- R10: A pulse on `eng_done` sets status bit 9, and the bit stays set until it is cleared.
- R11: While reset is held, the status register, the enable mask and `irq` are 0 and both buffers are empty.
- R12: Bit 0 is set while transmit lane 0 holds TX_TRIG (4) or fewer entries. Bit 5 is set while receive lane 0 holds RX_TRIG (4) or more entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_word | input | 1 | Host pushes a word into the transmit buffer |
| tx_wr_byte | input | 1 | Host pushes a byte into transmit lane 0 |
| tx_wdata | input | 32 | Host transmit data |
| eng_tx_pop_word | input | 1 | Engine pops a word from the transmit buffer |
| eng_tx_pop_byte | input | 1 | Engine pops a byte from transmit lane 0 |
| eng_tx_rdata | output | 32 | Transmit lane heads |
| eng_rx_push_word | input | 1 | Engine pushes a word into the receive buffer |
| eng_rx_push_byte | input | 1 | Engine pushes a byte into receive lane 0 |
| eng_rx_wdata | input | 32 | Engine receive data |
| rx_rd_word | input | 1 | Host pops a word from the receive buffer |
| rx_rd_byte | input | 1 | Host pops a byte from receive lane 0 |
| rx_rdata | output | 32 | Receive lane heads |
| eng_done | input | 1 | Engine completion pulse |
| stat_clr_we | input | 1 | Apply a clear mask to the status register |
| stat_clr_bits | input | 13 | Write-one-to-clear mask |
| irq_en_we | input | 1 | Load the interrupt enable mask |
| irq_en_bits | input | 13 | New enable mask |
| status | output | 13 | Sticky status register |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each side drives at most one of its word and byte strobes in a given cycle. They also assume that reset is applied from time zero. Both assumptions are themselves checked. The stimulus changes every input at the falling edge and raises a single strobe for exactly one cycle, so each access is counted once. Deliberate overflows and underflows are made only through the normal strobes, so the drop and flag logic is the only path the bench uses to reach bit 12.

// File: rtl/qlf_pkg.sv
// Package: status bit positions shared by the buffer top and its checker.
// Assumes a 13-bit status word; unused positions stay zero.
package qlf_pkg;
    localparam int STAT_W     = 13;
    localparam int B_TX_TRIG  = 0;
    localparam int B_TX_EMPTY = 1;
    localparam int B_TX_HALF  = 2;
    localparam int B_TX_FULL  = 3;
    localparam int B_RX_TRIG  = 5;
    localparam int B_RX_WORD  = 6;
    localparam int B_RX_HALF  = 7;
    localparam int B_RX_FULL  = 8;
    localparam int B_DONE     = 9;
    localparam int B_RX_BYTE  = 11;
    localparam int B_ILLEGAL  = 12;
endpackage

// File: rtl/qlf_lane.sv
// Module: one byte-wide FIFO lane with a head shown without delay.
// Assumes DEPTH is a power of two so the pointers wrap on their own;
// a push into a full lane or a pop from an empty lane is ignored here.
module qlf_lane #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    // Qualify the strobes against the current occupancy.
    always_comb begin
        do_push = push && (level != CW'(DEPTH));
        do_pop  = pop && (level != '0);
    end

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    // Head of the lane.
    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/qlf_buffer.sv
// Module: LANES parallel byte lanes with a word port (all lanes) and a
// byte port (lane 0). Assumes one producer and one consumer; the word
// strobe wins if both strobes of one side are raised together.
module qlf_buffer #(
    parameter  int LANES = 4,
    parameter  int DEPTH = 16,
    localparam int DW    = 8 * LANES,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_word,
    input  logic             push_byte,
    input  logic [DW-1:0]    wdata,
    input  logic             pop_word,
    input  logic             pop_byte,
    output logic [DW-1:0]    rdata,
    output logic [LANES-1:0] lane_full,
    output logic [LANES-1:0] lane_empty,
    output logic [CW-1:0]    lvl0,
    output logic             push_drop,
    output logic             pop_drop
);
    logic [CW-1:0]    lvl [LANES];
    logic             push_w_ok;
    logic             push_b_ok;
    logic             pop_w_ok;
    logic             pop_b_ok;

    // Decide which accesses may proceed and which are dropped.
    always_comb begin
        push_w_ok = push_word && !(|lane_full);
        push_b_ok = push_byte && !push_word && !lane_full[0];
        pop_w_ok  = pop_word && !(|lane_empty);
        pop_b_ok  = pop_byte && !pop_word && !lane_empty[0];
        push_drop = (push_word && (|lane_full)) ||
                    (push_byte && !push_word && lane_full[0]);
        pop_drop  = (pop_word && (|lane_empty)) ||
                    (pop_byte && !pop_word && lane_empty[0]);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic l_push;
        logic l_pop;
        // Lane 0 also serves the byte port.
        if (g == 0) begin : g_byte
            assign l_push = push_w_ok || push_b_ok;
            assign l_pop  = pop_w_ok || pop_b_ok;
        end else begin : g_word
            assign l_push = push_w_ok;
            assign l_pop  = pop_w_ok;
        end

        qlf_lane #(.DEPTH(DEPTH), .W(8)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (l_push),
            .pop   (l_pop),
            .wdata (wdata[8*g +: 8]),
            .rdata (rdata[8*g +: 8]),
            .level (lvl[g])
        );

        assign lane_full[g]  = (lvl[g] == CW'(DEPTH));
        assign lane_empty[g] = (lvl[g] == '0);
    end

    assign lvl0 = lvl[0];
endmodule

// File: rtl/qlf_status.sv
// Module: sticky write-one-to-clear status register with enable mask and
// level interrupt. Assumes set inputs win over a clear in the same cycle.
module qlf_status #(
    parameter int STAT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_bits,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic              en_we,
    input  logic [STAT_W-1:0] en_bits,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] clr_mask;

    // Clear mask applies only during a clear write.
    assign clr_mask = clr_we ? clr_bits : '0;

    // Sticky bits: keep, clear on request, then re-set from sources.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | set_bits;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_bits;
    end

    // Level interrupt from registered state only.
    assign irq = |(status & en_q);
endmodule

// File: rtl/quad_lane_fifo.sv
// Module: transmit and receive four-lane buffers with shared sticky status.
// Assumes each side raises at most one of its word/byte strobes per cycle.
module quad_lane_fifo
    import qlf_pkg::*;
#(
    parameter  int LANES   = 4,
    parameter  int DEPTH   = 16,
    parameter  int TX_TRIG = 4,
    parameter  int RX_TRIG = 4,
    localparam int DW      = 8 * LANES,
    localparam int CW      = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr_word,
    input  logic              tx_wr_byte,
    input  logic [DW-1:0]     tx_wdata,
    input  logic              eng_tx_pop_word,
    input  logic              eng_tx_pop_byte,
    output logic [DW-1:0]     eng_tx_rdata,
    input  logic              eng_rx_push_word,
    input  logic              eng_rx_push_byte,
    input  logic [DW-1:0]     eng_rx_wdata,
    input  logic              rx_rd_word,
    input  logic              rx_rd_byte,
    output logic [DW-1:0]     rx_rdata,
    input  logic              eng_done,
    input  logic              stat_clr_we,
    input  logic [STAT_W-1:0] stat_clr_bits,
    input  logic              irq_en_we,
    input  logic [STAT_W-1:0] irq_en_bits,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [LANES-1:0]  tx_lane_full;
    logic [LANES-1:0]  tx_lane_empty;
    logic [LANES-1:0]  rx_lane_full;
    logic [LANES-1:0]  rx_lane_empty;
    logic [CW-1:0]     tx_lvl0;
    logic [CW-1:0]     rx_lvl0;
    logic              tx_push_drop;
    logic              tx_pop_drop;
    logic              rx_push_drop;
    logic              rx_pop_drop;
    logic              rx_word_avail;
    logic [STAT_W-1:0] set_bits;

    // Host-to-engine buffer.
    qlf_buffer #(.LANES(LANES), .DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_word  (tx_wr_word),
        .push_byte  (tx_wr_byte),
        .wdata      (tx_wdata),
        .pop_word   (eng_tx_pop_word),
        .pop_byte   (eng_tx_pop_byte),
        .rdata      (eng_tx_rdata),
        .lane_full  (tx_lane_full),
        .lane_empty (tx_lane_empty),
        .lvl0       (tx_lvl0),
        .push_drop  (tx_push_drop),
        .pop_drop   (tx_pop_drop)
    );

    // Engine-to-host buffer.
    qlf_buffer #(.LANES(LANES), .DEPTH(DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_word  (eng_rx_push_word),
        .push_byte  (eng_rx_push_byte),
        .wdata      (eng_rx_wdata),
        .pop_word   (rx_rd_word),
        .pop_byte   (rx_rd_byte),
        .rdata      (rx_rdata),
        .lane_full  (rx_lane_full),
        .lane_empty (rx_lane_empty),
        .lvl0       (rx_lvl0),
        .push_drop  (rx_push_drop),
        .pop_drop   (rx_pop_drop)
    );

    assign rx_word_avail = ~(|rx_lane_empty);

    // Gather level conditions and one-cycle events into set requests.
    always_comb begin
        set_bits             = '0;
        set_bits[B_TX_TRIG]  = (tx_lvl0 <= CW'(TX_TRIG));
        set_bits[B_TX_EMPTY] = &tx_lane_empty;
        set_bits[B_TX_HALF]  = (tx_lvl0 >= CW'(DEPTH / 2));
        set_bits[B_TX_FULL]  = |tx_lane_full;
        set_bits[B_RX_TRIG]  = (rx_lvl0 >= CW'(RX_TRIG));
        set_bits[B_RX_WORD]  = rx_word_avail;
        set_bits[B_RX_HALF]  = (rx_lvl0 >= CW'(DEPTH / 2));
        set_bits[B_RX_FULL]  = |rx_lane_full;
        set_bits[B_DONE]     = eng_done;
        set_bits[B_RX_BYTE]  = !rx_lane_empty[0];
        set_bits[B_ILLEGAL]  = tx_push_drop | tx_pop_drop |
                               rx_push_drop | rx_pop_drop;
    end

    // Status, mask and interrupt.
    qlf_status #(.STAT_W(STAT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_we   (stat_clr_we),
        .clr_bits (stat_clr_bits),
        .en_we    (irq_en_we),
        .en_bits  (irq_en_bits),
        .status   (status),
        .irq      (irq)
    );
endmodule

// File: rtl/qlf_chk.sv
// Module: property checker for quad_lane_fifo, attached by bind.
// Assumes reset is asserted from time zero.
module qlf_chk
    import qlf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] status,
    input logic              irq,
    input logic              stat_clr_we,
    input logic [STAT_W-1:0] stat_clr_bits,
    input logic              tx_wr_word,
    input logic              tx_wr_byte,
    input logic              eng_tx_pop_word,
    input logic              eng_tx_pop_byte,
    input logic              eng_rx_push_word,
    input logic              eng_rx_push_byte,
    input logic              rx_rd_word,
    input logic              rx_rd_byte,
    input logic              rx_word_avail,
    input logic [CW-1:0]     tx_lvl0
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lvl0 <= CW'(DEPTH));

    // R4
    word_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_word && !rx_word_avail) |=> status[B_ILLEGAL]);

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_we |=> ((status & $past(status)) == $past(status)));

    // R8
    clear_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_we |=> (((status | $past(stat_clr_bits)) & $past(status)) == $past(status)));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0 && !irq));

    // R1 (strobe assumption: one access kind per side)
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_wr_word, tx_wr_byte}) && $onehot0({eng_tx_pop_word, eng_tx_pop_byte}) &&
        $onehot0({eng_rx_push_word, eng_rx_push_byte}) && $onehot0({rx_rd_word, rx_rd_byte}));
endmodule

bind quad_lane_fifo qlf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .status           (status),
    .irq              (irq),
    .stat_clr_we      (stat_clr_we),
    .stat_clr_bits    (stat_clr_bits),
    .tx_wr_word       (tx_wr_word),
    .tx_wr_byte       (tx_wr_byte),
    .eng_tx_pop_word  (eng_tx_pop_word),
    .eng_tx_pop_byte  (eng_tx_pop_byte),
    .eng_rx_push_word (eng_rx_push_word),
    .eng_rx_push_byte (eng_rx_push_byte),
    .rx_rd_word       (rx_rd_word),
    .rx_rd_byte       (rx_rd_byte),
    .rx_word_avail    (rx_word_avail),
    .tx_lvl0          (tx_lvl0)
);

// File: tb/quad_lane_fifo_bench.sv
module quad_lane_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    // Vector: {op[2:0], data[31:0], expected[31:0]}
    // op 0 host word write, 1 host byte write, 2 engine word pop, 3 engine byte pop,
    //    4 engine word push, 5 engine byte push, 6 host word read, 7 host byte read
    localparam logic [66:0] VEC [NVEC] = '{
        {3'd0, 32'h44332211, 32'h0},
        {3'd0, 32'h88776655, 32'h0},
        {3'd1, 32'h000000AB, 32'h0},
        {3'd2, 32'h0,        32'h44332211},
        {3'd2, 32'h0,        32'h88776655},
        {3'd3, 32'h0,        32'h000000AB},
        {3'd4, 32'hDEADBEEF, 32'h0},
        {3'd5, 32'h0000005A, 32'h0},
        {3'd6, 32'h0,        32'hDEADBEEF},
        {3'd7, 32'h0,        32'h0000005A},
        {3'd5, 32'h00000011, 32'h0},
        {3'd5, 32'h00000022, 32'h0},
        {3'd7, 32'h0,        32'h00000011},
        {3'd7, 32'h0,        32'h00000022}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr_word = 0, tx_wr_byte = 0;
    logic [31:0] tx_wdata = '0;
    logic        eng_tx_pop_word = 0, eng_tx_pop_byte = 0;
    logic [31:0] eng_tx_rdata;
    logic        eng_rx_push_word = 0, eng_rx_push_byte = 0;
    logic [31:0] eng_rx_wdata = '0;
    logic        rx_rd_word = 0, rx_rd_byte = 0;
    logic [31:0] rx_rdata;
    logic        eng_done = 0;
    logic        stat_clr_we = 0;
    logic [12:0] stat_clr_bits = '0;
    logic        irq_en_we = 0;
    logic [12:0] irq_en_bits = '0;
    logic [12:0] status;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    quad_lane_fifo u_quad_lane_fifo (
        .clk(clk), .rst_n(rst_n),
        .tx_wr_word(tx_wr_word), .tx_wr_byte(tx_wr_byte), .tx_wdata(tx_wdata),
        .eng_tx_pop_word(eng_tx_pop_word), .eng_tx_pop_byte(eng_tx_pop_byte),
        .eng_tx_rdata(eng_tx_rdata),
        .eng_rx_push_word(eng_rx_push_word), .eng_rx_push_byte(eng_rx_push_byte),
        .eng_rx_wdata(eng_rx_wdata),
        .rx_rd_word(rx_rd_word), .rx_rd_byte(rx_rd_byte), .rx_rdata(rx_rdata),
        .eng_done(eng_done),
        .stat_clr_we(stat_clr_we), .stat_clr_bits(stat_clr_bits),
        .irq_en_we(irq_en_we), .irq_en_bits(irq_en_bits),
        .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle access strobe; called and returns at a falling edge.
    task automatic do_op(input logic [2:0] op, input logic [31:0] d);
        case (op)
            3'd0: begin tx_wr_word = 1; tx_wdata = d; end
            3'd1: begin tx_wr_byte = 1; tx_wdata = d; end
            3'd2: eng_tx_pop_word = 1;
            3'd3: eng_tx_pop_byte = 1;
            3'd4: begin eng_rx_push_word = 1; eng_rx_wdata = d; end
            3'd5: begin eng_rx_push_byte = 1; eng_rx_wdata = d; end
            3'd6: rx_rd_word = 1;
            default: rx_rd_byte = 1;
        endcase
        @(negedge clk);
        tx_wr_word = 0; tx_wr_byte = 0; eng_tx_pop_word = 0; eng_tx_pop_byte = 0;
        eng_rx_push_word = 0; eng_rx_push_byte = 0; rx_rd_word = 0; rx_rd_byte = 0;
    endtask

    task automatic clr(input logic [12:0] m);
        stat_clr_we = 1; stat_clr_bits = m;
        @(negedge clk);
        stat_clr_we = 0; stat_clr_bits = '0;
    endtask

    task automatic set_en(input logic [12:0] m);
        irq_en_we = 1; irq_en_bits = m;
        @(negedge clk);
        irq_en_we = 0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        cyc(3);
        check("R11 status in reset", {19'd0, status}, 32'h0);
        check("R11 irq in reset", {31'd0, irq}, 32'h0);
        rst_n = 1;
        cyc(2);
        check("R12/R5 idle status", {19'd0, status}, 32'h003);
        clr(13'h1FFF);
        check("R7 clear with conditions held", {19'd0, status}, 32'h003);

        // Table walk: R1 word lanes, R2 byte lane, ordering
        for (int i = 0; i < NVEC; i++) begin
            logic [2:0]  op;
            logic [31:0] d;
            logic [31:0] e;
            op = VEC[i][66:64];
            d  = VEC[i][63:32];
            e  = VEC[i][31:0];
            case (op)
                3'd2: check("R1 tx word pop data", eng_tx_rdata, e);
                3'd3: check("R2 tx byte pop data", {24'd0, eng_tx_rdata[7:0]}, e);
                3'd6: check("R1 rx word read data", rx_rdata, e);
                3'd7: check("R2 rx byte read data", {24'd0, rx_rdata[7:0]}, e);
                default: ;
            endcase
            do_op(op, d);
        end
        cyc(1);
        check("R3 no drop in table", {31'd0, status[12]}, 32'h0);
        clr(13'h1FFF);
        check("R6 table leftovers cleared", {19'd0, status}, 32'h003);

        // R3: word capacity 64 bytes
        for (int i = 0; i < 16; i++) do_op(3'd0, {4{8'(i + 1)}});
        cyc(1);
        clr(13'h1FFF);
        check("R5 tx full and half", {19'd0, status}, 32'h00C);
        do_op(3'd0, 32'hFFFFFFFF);
        check("R3 word overflow flag", {31'd0, status[12]}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            check("R3 word drain data", eng_tx_rdata, {4{8'(i + 1)}});
            do_op(3'd2, 32'h0);
        end
        cyc(1);
        check("R6 full stays sticky", {31'd0, status[3]}, 32'h1);
        clr(13'h1FFF);
        check("R6 cleared after drain", {19'd0, status}, 32'h003);

        // R3: byte capacity 16 bytes
        for (int i = 0; i < 16; i++) do_op(3'd1, 32'(i));
        cyc(1);
        check("R3 sixteen bytes accepted", {31'd0, status[12]}, 32'h0);
        do_op(3'd1, 32'hEE);
        check("R3 byte overflow flag", {31'd0, status[12]}, 32'h1);
        check("R5 lane0 full", {31'd0, status[3]}, 32'h1);
        clr(13'h1FFF);
        do_op(3'd0, 32'h12345678);
        check("R3 word blocked by lane0", {31'd0, status[12]}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            if (i == 0 || i == 15)
                check("R2 byte drain order", {24'd0, eng_tx_rdata[7:0]}, 32'(i));
            do_op(3'd3, 32'h0);
        end
        cyc(1);
        clr(13'h1FFF);
        check("R3 dropped word left no data", {19'd0, status}, 32'h003);

        // R12: transmit trigger boundary
        for (int i = 0; i < 4; i++) do_op(3'd1, 32'h0);
        cyc(1);
        clr(13'h1FFF);
        check("R12 tx trig at 4", {19'd0, status}, 32'h001);
        do_op(3'd1, 32'h0);
        cyc(1);
        clr(13'h1FFF);
        check("R12 tx trig off at 5", {19'd0, status}, 32'h000);
        for (int i = 0; i < 5; i++) do_op(3'd3, 32'h0);
        cyc(1);
        clr(13'h1FFF);

        // R4: receive underflow
        do_op(3'd6, 32'h0);
        check("R4 word read empty", {31'd0, status[12]}, 32'h1);
        clr(13'h1FFF);
        do_op(3'd7, 32'h0);
        check("R4 byte read empty", {31'd0, status[12]}, 32'h1);
        clr(13'h1FFF);
        do_op(3'd5, 32'h77);
        cyc(1);
        clr(13'h1FFF);
        check("R5 byte avail only", {19'd0, status}, 32'h803);
        do_op(3'd6, 32'h0);
        check("R4 word read with lanes empty", {31'd0, status[12]}, 32'h1);
        check("R4 lane0 data kept", {24'd0, rx_rdata[7:0]}, 32'h77);
        do_op(3'd7, 32'h0);
        cyc(1);
        clr(13'h1FFF);
        check("R4 rx emptied", {19'd0, status}, 32'h003);

        // R12: receive trigger boundary
        for (int i = 0; i < 3; i++) do_op(3'd5, 32'h0);
        cyc(1);
        clr(13'h1FFF);
        check("R12 rx trig off at 3", {19'd0, status}, 32'h803);
        do_op(3'd5, 32'h0);
        cyc(1);
        clr(13'h1FFF);
        check("R12 rx trig at 4", {19'd0, status}, 32'h823);
        for (int i = 0; i < 4; i++) do_op(3'd7, 32'h0);
        cyc(1);
        clr(13'h1FFF);

        // R5: receive half and full
        for (int i = 0; i < 8; i++) do_op(3'd4, 32'h01010101 * (i + 1));
        cyc(1);
        clr(13'h1FFF);
        check("R5 rx half", {19'd0, status}, 32'h8E3);
        for (int i = 8; i < 16; i++) do_op(3'd4, 32'h01010101 * (i + 1));
        cyc(1);
        clr(13'h1FFF);
        check("R5 rx full", {19'd0, status}, 32'h9E3);
        for (int i = 0; i < 16; i++) begin
            if (i == 15) check("R1 rx last word", rx_rdata, 32'h10101010);
            do_op(3'd6, 32'h0);
        end
        cyc(1);
        clr(13'h1FFF);
        check("R5 rx drained", {19'd0, status}, 32'h003);

        // R9: interrupt mask and level
        set_en(13'h1000);
        check("R9 masked source idle", {31'd0, irq}, 32'h0);
        do_op(3'd6, 32'h0);
        check("R9 irq raised", {31'd0, irq}, 32'h1);
        cyc(3);
        check("R9 irq held", {31'd0, irq}, 32'h1);
        clr(13'h1000);
        check("R9 irq dropped on clear", {31'd0, irq}, 32'h0);
        set_en(13'h0002);
        check("R9 irq from held empty", {31'd0, irq}, 32'h1);
        set_en(13'h0000);
        check("R9 irq off when masked", {31'd0, irq}, 32'h0);

        // R10 and R8: done flag and clear scope
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        cyc(2);
        check("R10 done sticky", {31'd0, status[9]}, 32'h1);
        do_op(3'd7, 32'h0);
        clr(13'h0200);
        check("R8 done cleared", {31'd0, status[9]}, 32'h0);
        check("R8 illegal kept", {31'd0, status[12]}, 32'h1);
        clr(13'h1000);
        check("R8 all clear", {19'd0, status}, 32'h003);

        finish_run();
    end
endmodule